// File: doc/BRIEF.md
# Receive Buffer and Completion Queue Engine

This engine sits between a receive MAC and system memory. It manages two circular queues in memory: a free-buffer queue that software fills with buffer descriptors, and a completion queue that the engine fills with status entries. For each incoming frame, the engine does four things in order. It fetches the next buffer descriptor, writes the frame words into that buffer, posts an 8-byte status entry, and advances both queue pointers.

Software grants entries to the engine with credits. It writes a count to an enqueue register, and each frame uses one credit from each queue. If either queue has no credit when a frame arrives, the engine still takes the whole frame from the MAC. It writes nothing to memory and adds one to a drop counter. When a status entry is posted, a receive interrupt bit is set. Software can read that bit without side effects, or through a second address that clears it on read.

Top module: `rxq_engine`

## Requirements
- R1: The register port uses word addresses `cfg_addr`, and reads are combinational:
  - 0: buffer-queue base
  - 1: buffer-queue length in bytes
  - 2: buffer-queue current address (read only)
  - 3: buffer-queue enqueue on write, remaining credit on read
  - 4 to 7: the same four registers for the completion queue
  - 8: interrupt enable in bit 2
  - 9: interrupt status in bit 2, read with no side effect
  - 10: interrupt status, cleared by the read
  - 11: drop count

  After reset every register reads 0.
- R2: For each accepted frame, the engine reads two words at the buffer-queue current address (+0, +4). The first word is the buffer address. Bits 30:16 of the second word are the buffer index, and its other bits are ignored.
- R3: Frame words are written one by one to consecutive word addresses, starting at the buffer address.
- R4: Completion word 0 is built as follows:
  - bit 31 is set (processed)
  - bit 30 is set only when all `fr_err` bits are zero
  - bits 29 and 28 are set (end of frame, end of buffer)
  - bits 21:16 copy `fr_err[5:0]`, which are receive error, overrun, framing, runt, extra data and CRC error, in that order
  - bit 15 copies `fr_crc_incl`
  - all other bits are zero
- R5: Completion word 1 has bit 31 set, the buffer index in bits 30:16, and `fr_len` from the last beat in bits 15:0. It is written at the completion-queue current address +4, and word 0 is written at +0.
- R6: Both completion words are written only after the frame's last data write.
- R7: After each posted frame, both current addresses advance by 8. A current address returns to its base when base + length is reached. Writing a base register also loads the current address with the same value.
- R8: Writing N to an enqueue register adds N to that queue's credit. Each posted frame takes one credit from each queue.
- R9: If either credit is zero when a frame starts, every beat of the frame is still accepted. There is no memory access, both current addresses and credits stay the same, and the drop count goes up by one.
- R10: Status bit 2 is set when a frame is posted and stays set until address 10 is read. `irq` is status AND enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe (drives read-to-clear) |
| cfg_addr | input | 4 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data |
| fr_valid | input | 1 | Frame beat valid |
| fr_data | input | 32 | Frame data word |
| fr_last | input | 1 | Last beat of frame |
| fr_len | input | 16 | Frame length in bytes, valid on the last beat |
| fr_err | input | 6 | Error flags, valid on the last beat |
| fr_crc_incl | input | 1 | CRC is included in the data, valid on the last beat |
| fr_ready | output | 1 | Beat accepted at the next rising edge |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access completes at this rising edge |
| irq | output | 1 | Receive interrupt |

## Verification
The bench covers the following corner cases:
- **Frame with no credit.** It sends frames when neither queue has credit, and again when only the buffer queue has credit. An engine that checked only one queue would post into an ungranted slot.
- **Wrap.** It drives both queues through a full wrap and then sends one more frame. A pointer that missed the wrap would post past the end of the ring, and a credit that failed to reach zero would overwrite live entries.
- **Write order.** It checks that the completion words are written after the last data word. A design that posted the status early would let software see a frame whose data is not yet complete.
- **Interrupt paths.** It checks the masked interrupt, the side-effect-free status read and the read-to-clear path. Getting either read path wrong would lose an interrupt or leave one stuck.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int unsigned RXQ_ENTRY_BYTES = 8;
    localparam int unsigned RXQ_IRQ_BIT     = 2;

    localparam logic [3:0] RA_DQ_BASE = 4'd0;
    localparam logic [3:0] RA_DQ_LEN  = 4'd1;
    localparam logic [3:0] RA_DQ_CUR  = 4'd2;
    localparam logic [3:0] RA_DQ_ENQ  = 4'd3;
    localparam logic [3:0] RA_SQ_BASE = 4'd4;
    localparam logic [3:0] RA_SQ_LEN  = 4'd5;
    localparam logic [3:0] RA_SQ_CUR  = 4'd6;
    localparam logic [3:0] RA_SQ_ENQ  = 4'd7;
    localparam logic [3:0] RA_INT_EN  = 4'd8;
    localparam logic [3:0] RA_INT_STS = 4'd9;
    localparam logic [3:0] RA_INT_CLR = 4'd10;
    localparam logic [3:0] RA_DROPS   = 4'd11;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DESC0,
        ST_DESC1,
        ST_TAKE,
        ST_WRITE,
        ST_STS0,
        ST_STS1,
        ST_DROP
    } rxq_state_e;

    function automatic logic [31:0] rxq_word0(input logic [5:0] err, input logic crc_incl);
        logic [31:0] w;
        w          = '0;
        w[31]      = 1'b1;
        w[30]      = ~|err;
        w[29]      = 1'b1;
        w[28]      = 1'b1;
        w[21:16]   = err;
        w[15]      = crc_incl;
        return w;
    endfunction

    function automatic logic [31:0] rxq_word1(input logic [14:0] idx, input logic [15:0] len);
        return {1'b1, idx, len};
    endfunction

endpackage

// File: rtl/rxq_ring.sv
module rxq_ring #(
    parameter int unsigned AW = 32,
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          base_wr,
    input  logic          len_wr,
    input  logic          enq_wr,
    input  logic [31:0]   wdata,
    input  logic          advance,
    output logic [AW-1:0] base_q,
    output logic [AW-1:0] len_q,
    output logic [AW-1:0] cur_q,
    output logic [CW-1:0] credit_q
);
    localparam logic [AW-1:0] STEP = AW'(rxq_pkg::RXQ_ENTRY_BYTES);

    typedef struct packed {
        logic [AW-1:0] base;
        logic [AW-1:0] len;
        logic [AW-1:0] cur;
        logic [CW-1:0] credit;
    } ring_t;

    ring_t r_d, r_q;
    logic [AW-1:0] step_addr;
    logic [AW-1:0] end_addr;
    logic [CW-1:0] add_n;

    always_comb begin
        r_d       = r_q;
        step_addr = r_q.cur + STEP;
        end_addr  = r_q.base + r_q.len;
        add_n     = enq_wr ? wdata[CW-1:0] : '0;
        if (advance) begin
            r_d.cur = (step_addr >= end_addr) ? r_q.base : step_addr;
        end
        if (base_wr) begin
            r_d.base = wdata[AW-1:0];
            r_d.cur  = wdata[AW-1:0];
        end
        if (len_wr) begin
            r_d.len = wdata[AW-1:0];
        end
        r_d.credit = r_q.credit + add_n - (advance ? CW'(1) : CW'(0));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign base_q   = r_q.base;
    assign len_q    = r_q.len;
    assign cur_q    = r_q.cur;
    assign credit_q = r_q.credit;

    AST_CREDIT_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        advance |-> (credit_q != '0)); // R8

    AST_CUR_STAYS_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !base_wr && !len_wr && len_q != '0 && (cur_q - base_q) < len_q)
        |=> ((cur_q - base_q) < len_q)); // R7

endmodule

// File: rtl/rxq_irq.sv
module rxq_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic rd_clr,
    input  logic en_wr,
    input  logic en_bit,
    output logic en_q,
    output logic sts_q,
    output logic irq
);
    typedef struct packed {
        logic en;
        logic sts;
    } irq_t;

    irq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (en_wr)   s_d.en  = en_bit;
        if (rd_clr)  s_d.sts = 1'b0;
        if (set_evt) s_d.sts = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign en_q  = s_q.en;
    assign sts_q = s_q.sts;
    assign irq   = s_q.en & s_q.sts;

    AST_IRQ_SET_ON_POST: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> sts_q); // R10

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_q && !rd_clr) |=> sts_q); // R10

endmodule

// File: rtl/rxq_engine.sv
module rxq_engine #(
    parameter int unsigned AW = 32,
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic          cfg_rd,
    input  logic [3:0]    cfg_addr,
    input  logic [31:0]   cfg_wdata,
    output logic [31:0]   cfg_rdata,
    input  logic          fr_valid,
    input  logic [31:0]   fr_data,
    input  logic          fr_last,
    input  logic [15:0]   fr_len,
    input  logic [5:0]    fr_err,
    input  logic          fr_crc_incl,
    output logic          fr_ready,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    input  logic          mem_ack,
    output logic          irq
);
    import rxq_pkg::*;

    localparam logic [AW-1:0] WORD_STEP = AW'(4);

    typedef struct packed {
        rxq_state_e    st;
        logic [AW-1:0] buf_addr;
        logic [14:0]   idx;
        logic [AW-1:0] off;
        logic [31:0]   data;
        logic          last;
        logic [15:0]   len;
        logic [5:0]    err;
        logic          crc;
        logic [CW-1:0] drops;
    } eng_t;

    eng_t e_d, e_q;

    logic [AW-1:0] dq_base, dq_len, dq_cur, sq_base, sq_len, sq_cur;
    logic [CW-1:0] dq_credit, sq_credit;
    logic          advance;
    logic          irq_en, irq_sts;
    logic          rd_clr;

    // register decode
    logic dq_base_wr, dq_len_wr, dq_enq_wr, sq_base_wr, sq_len_wr, sq_enq_wr, en_wr;
    assign dq_base_wr = cfg_wr && cfg_addr == RA_DQ_BASE;
    assign dq_len_wr  = cfg_wr && cfg_addr == RA_DQ_LEN;
    assign dq_enq_wr  = cfg_wr && cfg_addr == RA_DQ_ENQ;
    assign sq_base_wr = cfg_wr && cfg_addr == RA_SQ_BASE;
    assign sq_len_wr  = cfg_wr && cfg_addr == RA_SQ_LEN;
    assign sq_enq_wr  = cfg_wr && cfg_addr == RA_SQ_ENQ;
    assign en_wr      = cfg_wr && cfg_addr == RA_INT_EN;
    assign rd_clr     = cfg_rd && cfg_addr == RA_INT_CLR;

    rxq_ring #(.AW(AW), .CW(CW)) i_dq (
        .clk(clk), .rst_n(rst_n),
        .base_wr(dq_base_wr), .len_wr(dq_len_wr), .enq_wr(dq_enq_wr),
        .wdata(cfg_wdata), .advance(advance),
        .base_q(dq_base), .len_q(dq_len), .cur_q(dq_cur), .credit_q(dq_credit)
    );

    rxq_ring #(.AW(AW), .CW(CW)) i_sq (
        .clk(clk), .rst_n(rst_n),
        .base_wr(sq_base_wr), .len_wr(sq_len_wr), .enq_wr(sq_enq_wr),
        .wdata(cfg_wdata), .advance(advance),
        .base_q(sq_base), .len_q(sq_len), .cur_q(sq_cur), .credit_q(sq_credit)
    );

    rxq_irq i_irq (
        .clk(clk), .rst_n(rst_n),
        .set_evt(advance), .rd_clr(rd_clr),
        .en_wr(en_wr), .en_bit(cfg_wdata[RXQ_IRQ_BIT]),
        .en_q(irq_en), .sts_q(irq_sts), .irq(irq)
    );

    // read mux
    always_comb begin
        cfg_rdata = '0;
        case (cfg_addr)
            RA_DQ_BASE: cfg_rdata = 32'(dq_base);
            RA_DQ_LEN:  cfg_rdata = 32'(dq_len);
            RA_DQ_CUR:  cfg_rdata = 32'(dq_cur);
            RA_DQ_ENQ:  cfg_rdata = 32'(dq_credit);
            RA_SQ_BASE: cfg_rdata = 32'(sq_base);
            RA_SQ_LEN:  cfg_rdata = 32'(sq_len);
            RA_SQ_CUR:  cfg_rdata = 32'(sq_cur);
            RA_SQ_ENQ:  cfg_rdata = 32'(sq_credit);
            RA_INT_EN:  cfg_rdata[RXQ_IRQ_BIT] = irq_en;
            RA_INT_STS: cfg_rdata[RXQ_IRQ_BIT] = irq_sts;
            RA_INT_CLR: cfg_rdata[RXQ_IRQ_BIT] = irq_sts;
            RA_DROPS:   cfg_rdata = 32'(e_q.drops);
            default:    cfg_rdata = '0;
        endcase
    end

    // engine sequencing
    always_comb begin
        e_d       = e_q;
        advance   = 1'b0;
        fr_ready  = (e_q.st == ST_TAKE) || (e_q.st == ST_DROP);
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (e_q.st)
            ST_IDLE: begin
                if (fr_valid) begin
                    if (dq_credit == '0 || sq_credit == '0) begin
                        e_d.st    = ST_DROP;
                        e_d.drops = e_q.drops + CW'(1);
                    end else begin
                        e_d.st = ST_DESC0;
                    end
                end
            end
            ST_DESC0: begin
                mem_req  = 1'b1;
                mem_addr = dq_cur;
                if (mem_ack) begin
                    e_d.buf_addr = mem_rdata[AW-1:0];
                    e_d.st       = ST_DESC1;
                end
            end
            ST_DESC1: begin
                mem_req  = 1'b1;
                mem_addr = dq_cur + WORD_STEP;
                if (mem_ack) begin
                    e_d.idx = mem_rdata[30:16];
                    e_d.off = '0;
                    e_d.st  = ST_TAKE;
                end
            end
            ST_TAKE: begin
                if (fr_valid) begin
                    e_d.data = fr_data;
                    e_d.last = fr_last;
                    e_d.len  = fr_len;
                    e_d.err  = fr_err;
                    e_d.crc  = fr_crc_incl;
                    e_d.st   = ST_WRITE;
                end
            end
            ST_WRITE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = e_q.buf_addr + e_q.off;
                mem_wdata = e_q.data;
                if (mem_ack) begin
                    e_d.off = e_q.off + WORD_STEP;
                    e_d.st  = e_q.last ? ST_STS0 : ST_TAKE;
                end
            end
            ST_STS0: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = sq_cur;
                mem_wdata = rxq_word0(e_q.err, e_q.crc);
                if (mem_ack) e_d.st = ST_STS1;
            end
            ST_STS1: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = sq_cur + WORD_STEP;
                mem_wdata = rxq_word1(e_q.idx, e_q.len);
                if (mem_ack) begin
                    advance = 1'b1;
                    e_d.st  = ST_IDLE;
                end
            end
            ST_DROP: begin
                if (fr_valid && fr_last) e_d.st = ST_IDLE;
            end
            default: e_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_q    <= '0;
            e_q.st <= ST_IDLE;
        end else begin
            e_q <= e_d;
        end
    end

    AST_DROP_NO_MEMORY: assert property (@(posedge clk) disable iff (!rst_n)
        (e_q.st == ST_DROP) |-> !mem_req); // R9

    AST_POST_HAS_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
        (e_q.st == ST_STS0) |-> (dq_credit != '0 && sq_credit != '0)); // R8

    AST_TAKE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        fr_ready |-> !mem_req); // R3

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R2

endmodule

// File: tb/test_rxq_engine.sv
`timescale 1ns/1ps
module test_rxq_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        fr_valid = 1'b0, fr_last = 1'b0, fr_crc_incl = 1'b0;
    logic [31:0] fr_data = '0;
    logic [15:0] fr_len = '0;
    logic [5:0]  fr_err = '0;
    logic        fr_ready;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;

    logic [31:0] mem  [0:4095];
    int          wseq [0:4095];
    int          seqn = 0;
    int          wcount = 0;

    always #4 clk = ~clk;

    rxq_engine i_rxq_engine (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .fr_valid(fr_valid), .fr_data(fr_data), .fr_last(fr_last),
        .fr_len(fr_len), .fr_err(fr_err), .fr_crc_incl(fr_crc_incl),
        .fr_ready(fr_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .irq(irq)
    );

    // memory model: answers every request in one cycle
    always @(negedge clk) begin
        mem_ack <= mem_req;
        if (mem_req) begin
            if (mem_we) begin
                mem[mem_addr[13:2]]  <= mem_wdata;
                seqn                  = seqn + 1;
                wseq[mem_addr[13:2]] <= seqn;
                wcount                = wcount + 1;
            end else begin
                mem_rdata <= mem[mem_addr[13:2]];
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [3:0] a, input logic [31:0] d);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic cfg_read(input logic [3:0] a, output logic [31:0] d);
        cfg_rd = 1'b1; cfg_addr = a;
        #1 d = cfg_rdata;
        @(negedge clk);
        cfg_rd = 1'b0;
    endtask

    task automatic send_frame(input int n, input logic [31:0] seed, input logic [15:0] len,
                              input logic [5:0] err, input logic crc);
        for (int i = 0; i < n; i++) begin
            fr_valid = 1'b1; fr_data = seed + 32'(i); fr_last = (i == n - 1);
            fr_len = len; fr_err = err; fr_crc_incl = crc;
            while (!fr_ready) @(negedge clk);
            @(negedge clk);
        end
        fr_valid = 1'b0; fr_last = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    localparam logic [31:0] DQB = 32'h1000;
    localparam logic [31:0] SQB = 32'h2000;
    localparam logic [31:0] BUFB = 32'h3000;

    function automatic logic [31:0] mrd(input logic [31:0] a);
        return mem[a[13:2]];
    endfunction

    task automatic t_reset;
        logic [31:0] d;
        chk("R1 reset irq", 32'(irq), 0);
        chk("R1 reset mem_req", 32'(mem_req), 0);
        for (int a = 0; a < 12; a++) begin
            cfg_read(4'(a), d);
            chk("R1 reset register", d, 0);
        end
    endtask

    task automatic t_setup;
        logic [31:0] d;
        for (int i = 0; i < 4; i++) begin
            mem[(DQB >> 2) + 2*i]     = BUFB + 32'(i) * 32'h100;
            mem[(DQB >> 2) + 2*i + 1] = 32'h8000_0000 | (32'(i) << 16) | 32'h100;
        end
        cfg_write(4'd0, DQB); cfg_write(4'd1, 32);
        cfg_write(4'd4, SQB); cfg_write(4'd5, 32);
        cfg_read(4'd2, d); chk("R7 base write loads current", d, DQB);
        cfg_read(4'd6, d); chk("R7 base write loads current sq", d, SQB);
    endtask

    task automatic t_drop_no_credit;
        logic [31:0] d;
        int w0;
        w0 = wcount;
        send_frame(2, 32'hAA00, 8, 0, 0);
        chk("R9 no memory write on drop", 32'(wcount), 32'(w0));
        cfg_read(4'd11, d); chk("R9 drop count 1", d, 1);
        cfg_write(4'd3, 4);
        send_frame(3, 32'hAB00, 12, 0, 0);
        chk("R9 no write, status credit zero", 32'(wcount), 32'(w0));
        cfg_read(4'd11, d); chk("R9 drop count 2", d, 2);
        cfg_read(4'd3, d); chk("R9 buffer credit kept", d, 4);
        cfg_read(4'd2, d); chk("R9 current kept", d, DQB);
        cfg_read(4'd9, d); chk("R10 no status on drop", d, 0);
    endtask

    task automatic t_good_frame;
        logic [31:0] d;
        cfg_write(4'd7, 4);
        cfg_read(4'd7, d); chk("R8 enqueue adds credit", d, 4);
        send_frame(3, 32'hC0DE_0000, 12, 0, 0);
        for (int i = 0; i < 3; i++)
            chk("R3 data word in buffer 0", mrd(BUFB + 32'(4*i)), 32'hC0DE_0000 + 32'(i));
        chk("R4 good word0", mrd(SQB), 32'hF000_0000);
        chk("R5 word1", mrd(SQB + 4), 32'h8000_000C);
        chk("R6 word0 after last data", 32'(wseq[(SQB >> 2)] > wseq[(BUFB >> 2) + 2]), 1);
        chk("R6 word1 after last data", 32'(wseq[(SQB >> 2) + 1] > wseq[(BUFB >> 2) + 2]), 1);
        cfg_read(4'd2, d); chk("R7 buffer queue advanced", d, DQB + 8);
        cfg_read(4'd6, d); chk("R7 status queue advanced", d, SQB + 8);
        cfg_read(4'd3, d); chk("R8 buffer credit used", d, 3);
        cfg_read(4'd7, d); chk("R8 status credit used", d, 3);
        chk("R10 irq masked while disabled", 32'(irq), 0);
        cfg_read(4'd9, d); chk("R10 status set", d, 4);
    endtask

    task automatic t_irq;
        logic [31:0] d;
        cfg_write(4'd8, 4);
        #1 chk("R10 irq when enabled", 32'(irq), 1);
        cfg_read(4'd9, d); chk("R10 preserving read", d, 4);
        #1 chk("R10 irq after preserving read", 32'(irq), 1);
        cfg_read(4'd10, d); chk("R10 clear read returns set", d, 4);
        #1 chk("R10 irq cleared", 32'(irq), 0);
        cfg_read(4'd9, d); chk("R10 status cleared", d, 0);
    endtask

    task automatic t_errors_and_wrap;
        logic [31:0] d;
        send_frame(2, 32'hE100, 8, 6'b000001, 1);
        chk("R4 crc error word0", mrd(SQB + 8), 32'hB001_8000);
        chk("R5 index 1 word1", mrd(SQB + 12), 32'h8001_0008);
        chk("R3 data in buffer 1", mrd(BUFB + 32'h104), 32'hE101);
        send_frame(1, 32'hE200, 4, 6'b110000, 0);
        chk("R4 rxerr overrun word0", mrd(SQB + 16), 32'hB030_0000);
        chk("R5 index 2 word1", mrd(SQB + 20), 32'h8002_0004);
        send_frame(4, 32'hE300, 16, 6'b000100, 0);
        chk("R4 runt word0", mrd(SQB + 24), 32'hB004_0000);
        chk("R5 index 3 word1", mrd(SQB + 28), 32'h8003_0010);
        cfg_read(4'd2, d); chk("R7 buffer queue wraps", d, DQB);
        cfg_read(4'd6, d); chk("R7 status queue wraps", d, SQB);
        cfg_read(4'd3, d); chk("R8 credit exhausted", d, 0);
        send_frame(1, 32'hF000, 4, 0, 0);
        cfg_read(4'd11, d); chk("R9 drop after wrap", d, 3);
        chk("R9 slot 0 untouched", mrd(SQB), 32'hF000_0000);
        mem[SQB >> 2] = 0; mem[(SQB >> 2) + 1] = 0;
        cfg_write(4'd3, 1); cfg_write(4'd7, 1);
        send_frame(1, 32'h5150, 4, 0, 0);
        chk("R2 reuse buffer 0 after wrap", mrd(BUFB), 32'h5150);
        chk("R5 reuse index 0", mrd(SQB + 4), 32'h8000_0004);
        chk("R4 reuse word0", mrd(SQB), 32'hF000_0000);
        #1 chk("R10 irq after post", 32'(irq), 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4096; i++) begin mem[i] = '0; wseq[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_setup;
        t_drop_no_credit;
        t_good_frame;
        t_irq;
        t_errors_and_wrap;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule